// File: doc/BRIEF.md
# DDR2 Start-Up Command Sequencer

This block sits on the controller side of a DDR2 SDRAM channel and brings the memory from power-on to an operational state. After reset it keeps the clock-enable and on-die-termination pins low for a programmable stable-power wait. It then raises clock enable and drives the mandatory bring-up commands on the command bus: precharge-all, the extended and base mode-register writes, a DLL reset, refreshes, and an off-chip-driver default and exit pair. Only one command is driven in any cycle, and every other cycle carries a NOP.

All spacing is counted in controller clock cycles through parameters: the power-up wait, the quiet period after clock enable rises, the precharge time, the mode-register gap, the refresh time and the DLL settle window. The base and extended mode-register values come in as ports. The sequencer itself places the DLL-reset bit, the DLL-enable bit and the driver-calibration field. When the last step and the DLL settle window have elapsed, `init_done` rises and stays high until the next reset. Normal traffic can then start.

Top module: `ddr2_bringup_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block holds `cke` and `odt` low, `init_done` low and drives NOP, where NOP is `{cs_n,ras_n,cas_n,we_n}` = 0111.
- R2: After reset release, `cke` stays low for PWR_WAIT cycles and then stays high. While `cke` is low, and for NOP_WAIT cycles after it rises, only NOP is driven.
- R3: `odt` is low in every cycle of the sequence.
- R4: The commands appear in this order: precharge-all, write to EMR2, write to EMR3, write to EMR1, MR write with DLL reset, precharge-all, REF_CNT refreshes, MR write without DLL reset, EMR1 with driver default, EMR1 with driver calibration exit. No other command appears.
- R5: Mode-register writes use command code 0000, with the target selected by `ba[1:0]` (00 MR, 01 EMR1, 10 EMR2, 11 EMR3) and the upper bank bits zero. The EMR2 write carries `emr2_val` and the EMR3 write carries an all-zero address.
- R6: The next command follows a mode-register write after exactly T_MRD cycles, a precharge-all (code 0010) after exactly T_RP cycles, and a refresh (code 0001) after exactly T_RFC cycles. A delay parameter below 1 acts as 1.
- R7: Exactly REF_CNT refresh commands are issued, each with bank and address zero.
- R8: The first MR write carries `mr_val` with address bit 8 (DLL reset) forced to 1. The second MR write carries `mr_val` with bit 8 forced to 0.
- R9: All three EMR1 writes carry `emr1_val` with bit 0 forced to 0 (DLL enabled). Bits 9:7 (driver calibration) are forced to 000 on the first write and on the exit write, and to 111 on the driver-default write.
- R10: `init_done` rises DLL_SETTLE cycles after the slot that follows the calibration-exit write by T_MRD cycles, and stays high. This leaves well over DLL_SETTLE cycles after the DLL reset.
- R11: Precharge-all drives address bit 10 high with bank zero. Once `init_done` is high only NOP is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mr_val | input | ADDR_W | Base mode-register value (bit 8 is overridden) |
| emr1_val | input | ADDR_W | EMR1 value (bits 0 and 9:7 are overridden) |
| emr2_val | input | ADDR_W | EMR2 value |
| cke | output | 1 | Memory clock enable |
| odt | output | 1 | On-die termination control, held low |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address / mode-register select |
| addr | output | ADDR_W | Address / mode-register payload |
| init_done | output | 1 | High once the bring-up sequence has finished |

## Verification
The assertions assume that `mr_val`, `emr1_val` and `emr2_val` hold steady for the whole sequence and that reset is held for at least one clock edge before each run. The spacing checks also assume that each delay parameter is small enough to fit the checker's saturating gap counter. The bench changes the mode-register inputs only while reset is asserted, holds reset for several edges, and runs two complete sequences with different register patterns. One of those patterns sets every bit that the sequencer overrides, so the forcing of those bits is visible at the ports.

// File: rtl/ddr2_bringup_pkg.sv
// Shared definitions for the DDR2 bring-up sequencer.
// Command codes are the {cs_n, ras_n, cas_n, we_n} levels, and the fixed
// step positions are given up to the first refresh step.
package ddr2_bringup_pkg;

    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } cmd_t;

    localparam int STEP_PWR   = 0;
    localparam int STEP_CKE   = 1;
    localparam int STEP_PRE1  = 2;
    localparam int STEP_EMR2  = 3;
    localparam int STEP_EMR3  = 4;
    localparam int STEP_EMR1  = 5;
    localparam int STEP_MRDLL = 6;
    localparam int STEP_PRE2  = 7;
    localparam int STEP_REF0  = 8;

    // Number of steps that follow the refresh group (MR, OCD default, OCD exit, settle, done)
    localparam int STEP_TAIL  = 5;

    function automatic int clamp1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/ddr2_step_decode.sv
// Step decoder: maps the current step index to the command, bank select
// and address that the step issues in its first cycle.
// Assumes ADDR_W >= 11 and BA_W >= 2; steps without a command yield NOP.
module ddr2_step_decode
    import ddr2_bringup_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int BA_W    = 3,
    parameter int REF_CNT = 2,
    parameter int STEP_W  = 4
) (
    input  logic [STEP_W-1:0] step,
    input  logic [ADDR_W-1:0] mr_val,
    input  logic [ADDR_W-1:0] emr1_val,
    input  logic [ADDR_W-1:0] emr2_val,
    output cmd_t              cmd,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [STEP_W-1:0] ST_PRE1  = STEP_W'(STEP_PRE1);
    localparam logic [STEP_W-1:0] ST_EMR2  = STEP_W'(STEP_EMR2);
    localparam logic [STEP_W-1:0] ST_EMR3  = STEP_W'(STEP_EMR3);
    localparam logic [STEP_W-1:0] ST_EMR1  = STEP_W'(STEP_EMR1);
    localparam logic [STEP_W-1:0] ST_MRDLL = STEP_W'(STEP_MRDLL);
    localparam logic [STEP_W-1:0] ST_PRE2  = STEP_W'(STEP_PRE2);
    localparam logic [STEP_W-1:0] ST_REF0  = STEP_W'(STEP_REF0);
    localparam logic [STEP_W-1:0] ST_MRS   = STEP_W'(STEP_REF0 + REF_CNT);
    localparam logic [STEP_W-1:0] ST_OCDD  = STEP_W'(STEP_REF0 + REF_CNT + 1);
    localparam logic [STEP_W-1:0] ST_OCDX  = STEP_W'(STEP_REF0 + REF_CNT + 2);

    localparam logic [ADDR_W-1:0] DLL_RST_BIT = ADDR_W'(1) << 8;
    localparam logic [ADDR_W-1:0] DLL_OFF_BIT = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OCD_FIELD   = ADDR_W'(7) << 7;
    localparam logic [ADDR_W-1:0] PRE_ALL_BIT = ADDR_W'(1) << 10;

    logic [ADDR_W-1:0] emr1_base;

    // EMR1 with the DLL enabled and the driver calibration field cleared
    assign emr1_base = emr1_val & ~(DLL_OFF_BIT | OCD_FIELD);

    // Command table lookup for the current step
    always_comb begin
        cmd    = CMD_NOP;
        ba_o   = '0;
        addr_o = '0;
        if (step == ST_PRE1 || step == ST_PRE2) begin
            cmd    = CMD_PRE;
            addr_o = PRE_ALL_BIT;
        end else if (step == ST_EMR2) begin
            cmd    = CMD_MRS;
            ba_o   = BA_W'(2'd2);
            addr_o = emr2_val;
        end else if (step == ST_EMR3) begin
            cmd    = CMD_MRS;
            ba_o   = BA_W'(2'd3);
        end else if (step == ST_EMR1) begin
            cmd    = CMD_MRS;
            ba_o   = BA_W'(2'd1);
            addr_o = emr1_base;
        end else if (step == ST_MRDLL) begin
            cmd    = CMD_MRS;
            addr_o = mr_val | DLL_RST_BIT;
        end else if (step >= ST_REF0 && step < ST_MRS) begin
            cmd    = CMD_REF;
        end else if (step == ST_MRS) begin
            cmd    = CMD_MRS;
            addr_o = mr_val & ~DLL_RST_BIT;
        end else if (step == ST_OCDD) begin
            cmd    = CMD_MRS;
            ba_o   = BA_W'(2'd1);
            addr_o = emr1_base | OCD_FIELD;
        end else if (step == ST_OCDX) begin
            cmd    = CMD_MRS;
            ba_o   = BA_W'(2'd1);
            addr_o = emr1_base;
        end
    end

endmodule

// File: rtl/ddr2_step_delay.sv
// Step length lookup: returns how many cycles a step occupies, from its
// command slot to the next step's slot. Every length is at least 1.
module ddr2_step_delay
    import ddr2_bringup_pkg::*;
#(
    parameter int STEP_W     = 4,
    parameter int CNT_W      = 14,
    parameter int REF_CNT    = 2,
    parameter int PWR_WAIT   = 10000,
    parameter int NOP_WAIT   = 20,
    parameter int T_RP       = 3,
    parameter int T_MRD      = 2,
    parameter int T_RFC      = 7,
    parameter int DLL_SETTLE = 200
) (
    input  logic [STEP_W-1:0] step,
    output logic [CNT_W-1:0]  len
);

    localparam logic [STEP_W-1:0] ST_PWR    = STEP_W'(STEP_PWR);
    localparam logic [STEP_W-1:0] ST_CKE    = STEP_W'(STEP_CKE);
    localparam logic [STEP_W-1:0] ST_PRE1   = STEP_W'(STEP_PRE1);
    localparam logic [STEP_W-1:0] ST_PRE2   = STEP_W'(STEP_PRE2);
    localparam logic [STEP_W-1:0] ST_REF0   = STEP_W'(STEP_REF0);
    localparam logic [STEP_W-1:0] ST_MRS    = STEP_W'(STEP_REF0 + REF_CNT);
    localparam logic [STEP_W-1:0] ST_SETTLE = STEP_W'(STEP_REF0 + REF_CNT + 3);
    localparam logic [STEP_W-1:0] ST_DONE   = STEP_W'(STEP_REF0 + REF_CNT + 4);

    // Length per step class
    always_comb begin
        if (step == ST_PWR)                            len = CNT_W'(clamp1(PWR_WAIT));
        else if (step == ST_CKE)                       len = CNT_W'(clamp1(NOP_WAIT));
        else if (step == ST_PRE1 || step == ST_PRE2)   len = CNT_W'(clamp1(T_RP));
        else if (step >= ST_REF0 && step < ST_MRS)     len = CNT_W'(clamp1(T_RFC));
        else if (step == ST_SETTLE)                    len = CNT_W'(clamp1(DLL_SETTLE));
        else if (step >= ST_DONE)                      len = CNT_W'(1);
        else                                           len = CNT_W'(clamp1(T_MRD));
    end

endmodule

// File: rtl/ddr2_delay_timer.sv
// Single down-counter shared by all steps. It is loaded with (length-1)
// on each step change and flags the first cycle of a step. Assumes
// next_len >= 1.
module ddr2_delay_timer #(
    parameter int CNT_W     = 14,
    parameter int INIT_LOAD = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [CNT_W-1:0] next_len,
    output logic             expire,
    output logic             fresh
);

    logic [CNT_W-1:0] cnt;

    assign expire = (cnt == '0);

    // Reload on step change, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= CNT_W'(INIT_LOAD - 1);
            fresh <= 1'b1;
        end else if (advance) begin
            cnt   <= next_len - CNT_W'(1);
            fresh <= 1'b1;
        end else begin
            fresh <= 1'b0;
            if (cnt != '0) cnt <= cnt - CNT_W'(1);
        end
    end

endmodule

// File: rtl/ddr2_bringup_seq.sv
// DDR2 bring-up sequencer top. It steps through the fixed start-up order
// and issues each step's command in the step's first cycle, with NOP in
// all other cycles. Assumes the mode-register inputs are steady from
// reset release to init_done.
module ddr2_bringup_seq
    import ddr2_bringup_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int BA_W       = 3,
    parameter int REF_CNT    = 2,
    parameter int PWR_WAIT   = 10000,
    parameter int NOP_WAIT   = 20,
    parameter int T_RP       = 3,
    parameter int T_MRD      = 2,
    parameter int T_RFC      = 7,
    parameter int DLL_SETTLE = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mr_val,
    input  logic [ADDR_W-1:0] emr1_val,
    input  logic [ADDR_W-1:0] emr2_val,
    output logic              cke,
    output logic              odt,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    localparam int LAST_STEP = STEP_REF0 + REF_CNT + STEP_TAIL - 1;
    localparam int STEP_W    = $clog2(LAST_STEP + 1);
    localparam int MAX_A     = (clamp1(PWR_WAIT) > clamp1(DLL_SETTLE)) ? clamp1(PWR_WAIT) : clamp1(DLL_SETTLE);
    localparam int MAX_B     = (clamp1(T_RFC) > clamp1(NOP_WAIT)) ? clamp1(T_RFC) : clamp1(NOP_WAIT);
    localparam int MAX_C     = (clamp1(T_RP) > clamp1(T_MRD)) ? clamp1(T_RP) : clamp1(T_MRD);
    localparam int MAX_AB    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_LEN   = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
    localparam int CNT_W     = $clog2(MAX_LEN + 1);
    localparam logic [STEP_W-1:0] ST_PWR  = STEP_W'(STEP_PWR);
    localparam logic [STEP_W-1:0] ST_DONE = STEP_W'(LAST_STEP);

    logic [STEP_W-1:0] step;
    logic [STEP_W-1:0] step_nxt;
    logic [CNT_W-1:0]  nxt_len;
    logic              expire;
    logic              fresh;
    logic              advance;
    cmd_t              dec_cmd;
    cmd_t              bus_cmd;
    logic [BA_W-1:0]   dec_ba;
    logic [ADDR_W-1:0] dec_addr;

    assign advance  = expire && (step != ST_DONE);
    assign step_nxt = (step == ST_DONE) ? step : step + STEP_W'(1);

    // Step register: moves forward one step when the timer expires
    always_ff @(posedge clk) begin
        if (!rst_n)       step <= ST_PWR;
        else if (advance) step <= step_nxt;
    end

    ddr2_step_delay #(
        .STEP_W(STEP_W), .CNT_W(CNT_W), .REF_CNT(REF_CNT),
        .PWR_WAIT(PWR_WAIT), .NOP_WAIT(NOP_WAIT), .T_RP(T_RP),
        .T_MRD(T_MRD), .T_RFC(T_RFC), .DLL_SETTLE(DLL_SETTLE)
    ) u_len (
        .step (step_nxt),
        .len  (nxt_len)
    );

    ddr2_delay_timer #(
        .CNT_W(CNT_W), .INIT_LOAD(clamp1(PWR_WAIT))
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .next_len (nxt_len),
        .expire   (expire),
        .fresh    (fresh)
    );

    ddr2_step_decode #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .REF_CNT(REF_CNT), .STEP_W(STEP_W)
    ) u_dec (
        .step     (step),
        .mr_val   (mr_val),
        .emr1_val (emr1_val),
        .emr2_val (emr2_val),
        .cmd      (dec_cmd),
        .ba_o     (dec_ba),
        .addr_o   (dec_addr)
    );

    // Drive the step's command only in its first cycle, NOP otherwise
    always_comb begin
        bus_cmd = fresh ? dec_cmd : CMD_NOP;
        ba      = fresh ? dec_ba : '0;
        addr    = fresh ? dec_addr : '0;
    end

    assign {cs_n, ras_n, cas_n, we_n} = bus_cmd;
    assign cke       = (step != ST_PWR);
    assign odt       = 1'b0;
    assign init_done = (step == ST_DONE);

endmodule

// File: rtl/ddr2_bringup_chk.sv
// Protocol checker for the bring-up sequencer, bound to every instance.
// Tracks the kind of the last command and the gap since it with a
// saturating counter. Assumes mode inputs are steady during a run.
module ddr2_bringup_chk #(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 3,
    parameter int T_RP   = 3,
    parameter int T_MRD  = 2,
    parameter int T_RFC  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic              init_done
);

    localparam int GAP_W = 16;
    localparam logic [GAP_W-1:0] GAP_MAX = '1;
    localparam logic [GAP_W-1:0] MRD_E = GAP_W'((T_MRD < 1) ? 1 : T_MRD);
    localparam logic [GAP_W-1:0] RP_E  = GAP_W'((T_RP  < 1) ? 1 : T_RP);
    localparam logic [GAP_W-1:0] RFC_E = GAP_W'((T_RFC < 1) ? 1 : T_RFC);

    typedef enum logic [1:0] {K_NONE, K_MR, K_PRE, K_REF} kind_t;

    logic [3:0]       code;
    logic             is_cmd;
    kind_t            last_kind;
    logic [GAP_W-1:0] gap;

    assign code   = {cs_n, ras_n, cas_n, we_n};
    assign is_cmd = (code != 4'b0111);

    // Record the last command kind and count cycles since it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_kind <= K_NONE;
            gap       <= '0;
        end else if (is_cmd) begin
            gap <= GAP_W'(1);
            case (code)
                4'b0000: last_kind <= K_MR;
                4'b0010: last_kind <= K_PRE;
                4'b0001: last_kind <= K_REF;
                default: last_kind <= K_NONE;
            endcase
        end else if (gap != GAP_MAX) begin
            gap <= gap + GAP_W'(1);
        end
    end

    assert_cke_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);
    assert_nop_cke_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> !is_cmd);
    assert_emr3_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 4'b0000 && ba[1:0] == 2'b11) |-> (addr == '0));
    assert_mrd_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && last_kind == K_MR) |-> (gap >= MRD_E));
    assert_rp_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && last_kind == K_PRE) |-> (gap >= RP_E));
    assert_rfc_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && last_kind == K_REF) |-> (gap >= RFC_E));
    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    assert_prea_a10_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (code == 4'b0010) |-> addr[10]);
    assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (!is_cmd && cke));

endmodule

bind ddr2_bringup_seq ddr2_bringup_chk #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .addr      (addr),
    .init_done (init_done)
);

// File: tb/ddr2_bringup_seq_tb.sv
// Scoreboard bench: the driver task queues every expected command with its
// cycle number, and a monitor pops and compares them as they appear.
module ddr2_bringup_seq_tb;

    localparam int ADDR_W = 13, BA_W = 3, REF_CNT = 2;
    localparam int PWR_WAIT = 300, NOP_WAIT = 8, T_RP = 3, T_MRD = 2, T_RFC = 7, DLL_SETTLE = 200;

    typedef struct {
        int          cyc;
        logic [3:0]  code;
        logic [2:0]  bav;
        logic [12:0] adr;
        string       req;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [ADDR_W-1:0] mr_val = '0, emr1_val = '0, emr2_val = '0;
    logic cke, odt, cs_n, ras_n, cas_n, we_n, init_done;
    logic [BA_W-1:0] ba;
    logic [ADDR_W-1:0] addr;

    exp_t q[$];
    int checks = 0, bad = 0, cyc = 0, done_cyc = 0;
    int cke_bad = 0, odt_bad = 0, done_bad = 0;
    bit running = 0;

    always #10 clk = ~clk;

    ddr2_bringup_seq #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .REF_CNT(REF_CNT), .PWR_WAIT(PWR_WAIT),
        .NOP_WAIT(NOP_WAIT), .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC), .DLL_SETTLE(DLL_SETTLE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .mr_val(mr_val), .emr1_val(emr1_val), .emr2_val(emr2_val),
        .cke(cke), .odt(odt), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .init_done(init_done)
    );

    task automatic check(input bit ok, input string req, input string act, input string expv);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%s expected=%s", req, act, expv);
        end
    endtask

    task automatic push(input int c, input logic [3:0] code, input logic [2:0] b,
                        input logic [12:0] a, input string req);
        exp_t e;
        e.cyc = c; e.code = code; e.bav = b; e.adr = a; e.req = req;
        q.push_back(e);
    endtask

    // Monitor: compares each non-NOP command against the head of the queue
    always @(negedge clk) begin
        if (running) begin
            cyc++;
            if (cke !== (cyc >= PWR_WAIT)) cke_bad++;
            if (odt !== 1'b0) odt_bad++;
            if (init_done !== (cyc >= done_cyc)) done_bad++;
            if ({cs_n, ras_n, cas_n, we_n} !== 4'b0111) begin
                if (q.size() == 0) begin
                    check(0, "R11", $sformatf("cmd %b at cycle %0d", {cs_n, ras_n, cas_n, we_n}, cyc), "NOP");
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(cyc == e.cyc && {cs_n, ras_n, cas_n, we_n} === e.code && ba === e.bav && addr === e.adr,
                          e.req,
                          $sformatf("cyc=%0d cmd=%b ba=%0d addr=%h", cyc, {cs_n, ras_n, cas_n, we_n}, ba, addr),
                          $sformatf("cyc=%0d cmd=%b ba=%0d addr=%h", e.cyc, e.code, e.bav, e.adr));
                end
            end
            if (cyc >= done_cyc + 20) running = 0;
        end
    end

    // Driver: resets with new mode values, queues the expected sequence, runs it
    task automatic run_seq(input logic [12:0] mr, input logic [12:0] e1, input logic [12:0] e2);
        logic [12:0] e1b;
        int c;
        @(negedge clk);
        rst_n = 1'b0;
        mr_val = mr; emr1_val = e1; emr2_val = e2;
        repeat (3) @(negedge clk);
        check(cke === 1'b0 && odt === 1'b0 && init_done === 1'b0 &&
              {cs_n, ras_n, cas_n, we_n} === 4'b0111, "R1",
              $sformatf("cke=%b odt=%b done=%b cmd=%b", cke, odt, init_done, {cs_n, ras_n, cas_n, we_n}),
              "cke=0 odt=0 done=0 cmd=0111");
        e1b = e1 & ~13'h0381;
        c = PWR_WAIT + NOP_WAIT;
        push(c, 4'b0010, 3'd0, 13'h0400, "R4 R11 first precharge-all");  c += T_RP;
        push(c, 4'b0000, 3'd2, e2, "R5 EMR2 write");                     c += T_MRD;
        push(c, 4'b0000, 3'd3, 13'h0000, "R5 EMR3 write zero");          c += T_MRD;
        push(c, 4'b0000, 3'd1, e1b, "R9 EMR1 DLL enable");               c += T_MRD;
        push(c, 4'b0000, 3'd0, mr | 13'h0100, "R8 MR with DLL reset");   c += T_MRD;
        push(c, 4'b0010, 3'd0, 13'h0400, "R6 second precharge-all");     c += T_RP;
        for (int i = 0; i < REF_CNT; i++) begin
            push(c, 4'b0001, 3'd0, 13'h0000, "R7 refresh");              c += T_RFC;
        end
        push(c, 4'b0000, 3'd0, mr & ~13'h0100, "R8 MR DLL reset clear"); c += T_MRD;
        push(c, 4'b0000, 3'd1, e1b | 13'h0380, "R9 OCD default");        c += T_MRD;
        push(c, 4'b0000, 3'd1, e1b, "R9 OCD exit");                      c += T_MRD;
        done_cyc = c + DLL_SETTLE;
        cke_bad = 0; odt_bad = 0; done_bad = 0;
        #2;
        cyc = 0;
        running = 1;
        rst_n = 1'b1;
        wait (running == 0);
        check(q.size() == 0, "R4", $sformatf("%0d commands missing", q.size()), "0 missing");
        check(cke_bad == 0, "R2", $sformatf("%0d cke errors", cke_bad), "0");
        check(odt_bad == 0, "R3", $sformatf("%0d odt errors", odt_bad), "0");
        check(done_bad == 0, "R10", $sformatf("%0d init_done errors", done_bad), "0");
        q.delete();
    endtask

    initial begin
        run_seq(13'h0053, 13'h0044, 13'h0080);
        run_seq(13'h1B62, 13'h1387, 13'h1FFF);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 20);
        checks++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule